// File: doc/BRIEF.md
# Phase-Frequency Detector with Polarity, Deferred Power-Down and Lock Flag

This block compares two divided pulse streams, one derived from the reference oscillator and one from the VCO, and turns their rising edges into up and down commands for a charge pump. Each stream arms its own detector flop. When both flops are armed they are cleared together one cycle later, so the longer-lived command encodes the phase or frequency lead. When neither command is active, a tri-state indicator marks the pump as high impedance.

A polarity input exchanges the two commands for loops whose VCO has a negative tuning slope. A low-active power-down request is held off until the pump is idle, so that a pending correction is not cut short and the loop does not jump in frequency. A lock flag stays high while corrections are short and drops for every cycle in which a correction has lasted longer than a programmable window. A monitor output shows the sampled reference stream.

Top module: `phase_det`

## Requirements
- R1: After reset, up_o and dn_o are 0, tri_o is 1, lock_o is 1 and mon_o is 0.
- R2: A rising edge on ref_pulse_i sets the reference flop and a rising edge on vco_pulse_i sets the VCO flop; each is visible at the outputs one clock after the first clock edge that samples the input high.
- R3: When both flops are set, both are cleared on the next clock edge. A reference edge leading the VCO edge by k cycles gives k+1 cycles of up_o and 1 cycle of dn_o with pol_i high, and a VCO lead mirrors this.
- R4: With pol_i high, up_o follows the reference flop and dn_o the VCO flop; with pol_i low the two roles are exchanged.
- R5: tri_o is 1 exactly when neither up_o nor dn_o is 1.
- R6: A low on pwr_ni while either flop is set does not shorten the command in progress; power-down is entered on the clock edge after both flops are clear.
- R7: In power-down, up_o and dn_o stay 0, tri_o and lock_o stay 1, and input edges are ignored.
- R8: Power-down ends on the clock edge after pwr_ni returns high, with both flops cleared; an input already high at that time does not count as a new edge.
- R9: lock_o is 0 in each cycle where a flop has been continuously set for more than LOCK_WIN cycles (default 4), and 1 otherwise.
- R10: mon_o equals ref_pulse_i as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Divided reference pulse stream |
| vco_pulse_i | input | 1 | Divided VCO pulse stream |
| pol_i | input | 1 | Polarity: 1 normal, 0 up/down exchanged |
| pwr_ni | input | 1 | 0 requests power-down |
| up_o | output | 1 | Source command to the pump |
| dn_o | output | 1 | Sink command to the pump |
| tri_o | output | 1 | Pump in high-impedance state |
| lock_o | output | 1 | Lock flag, low while a correction overstays the window |
| mon_o | output | 1 | Sampled reference stream monitor |

## Verification
A flop that fails to clear shows as an up_o or dn_o pulse longer than k+1 cycles and, past the window, as lock_o dropping within LOCK_WIN+1 cycles of the missed clear. A power-down state entered too early truncates the command in progress on the very next cycle, while one that never exits leaves tri_o stuck high through the following pulse pair. A stale edge register on exit produces a spurious up_o one cycle after release, which the held-high input case exposes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_cmd_t;

  function automatic pump_cmd_t orient(input pump_cmd_t c, input logic pol);
    pump_cmd_t r;
    r.up = pol ? c.up : c.dn;
    r.dn = pol ? c.dn : c.up;
    return r;
  endfunction
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] prev_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= in_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise_o[g] = in_i[g] & ~prev_q[g];
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/pfd_flops.sv
module pfd_flops (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic vco_rise_i,
  input  logic hold_i,
  output logic ref_q_o,
  output logic vco_q_o
);
  logic ref_q, vco_q, both;

  assign both = ref_q & vco_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
    end else if (hold_i) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
    end else begin
      ref_q <= (ref_q & ~both) | ref_rise_i;
      vco_q <= (vco_q & ~both) | vco_rise_i;
    end
  end

  assign ref_q_o = ref_q;
  assign vco_q_o = vco_q;

  // R3: coincident flops reset together unless a fresh edge re-arms them
  a_r3_joint_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_q && vco_q && !ref_rise_i && !vco_rise_i) |=> (!ref_q && !vco_q));

  // R8: flops are empty on the cycle after a hold
  a_r8_clear_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!ref_q && !vco_q));
endmodule

// File: rtl/pfd_pwr.sv
module pfd_pwr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ni,
  input  logic busy_i,
  output logic enter_o,
  output logic pd_o
);
  logic pd_q;

  assign enter_o = ~pwr_ni & ~busy_i & ~pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pd_q <= 1'b0;
    else if (pwr_ni) pd_q <= 1'b0;
    else if (enter_o) pd_q <= 1'b1;
  end

  assign pd_o = pd_q;

  // R6: power-down only begins from an idle pump
  a_r6_enter_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> $past(!busy_i));

  // R8: release follows the request going high
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && pwr_ni) |=> !pd_q);
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int unsigned LOCK_WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic lock_o
);
  localparam int unsigned CntW = $clog2(LOCK_WIN + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(LOCK_WIN);

  logic [CntW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (!act_i)         run_q <= '0;
    else if (run_q < CntMax) run_q <= run_q + 1'b1;
  end

  // run_q counts prior consecutive active cycles
  assign lock_o = ~(act_i & (run_q >= CntMax));

  // R9: an unlock cycle always carries an active command
  a_r9_unlock_needs_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> act_i);

  // R9: a new correction cannot drop lock on its first cycle
  a_r9_first_cycle_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !$past(act_i)) |-> lock_o);
endmodule

// File: rtl/phase_det.sv
module phase_det #(
  parameter int unsigned LOCK_WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_pulse_i,
  input  logic vco_pulse_i,
  input  logic pol_i,
  input  logic pwr_ni,
  output logic up_o,
  output logic dn_o,
  output logic tri_o,
  output logic lock_o,
  output logic mon_o
);
  import pfd_pkg::*;

  logic [1:0] prev, rise;
  logic       ref_q, vco_q, enter, pd, lock_raw;
  pump_cmd_t  raw, cmd;

  pfd_edge #(.N(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({vco_pulse_i, ref_pulse_i}),
    .prev_o(prev),
    .rise_o(rise)
  );

  pfd_flops u_flops (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(rise[0]),
    .vco_rise_i(rise[1]),
    .hold_i    (pd | enter),
    .ref_q_o   (ref_q),
    .vco_q_o   (vco_q)
  );

  pfd_pwr u_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwr_ni (pwr_ni),
    .busy_i (ref_q | vco_q),
    .enter_o(enter),
    .pd_o   (pd)
  );

  pfd_lock #(.LOCK_WIN(LOCK_WIN)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (ref_q | vco_q),
    .lock_o(lock_raw)
  );

  assign raw.up = ref_q;
  assign raw.dn = vco_q;
  assign cmd    = orient(raw, pol_i);

  assign up_o   = cmd.up & ~pd;
  assign dn_o   = cmd.dn & ~pd;
  assign tri_o  = ~(up_o | dn_o);
  assign lock_o = lock_raw | pd;
  assign mon_o  = prev[0];

  // R7: power-down leaves the pump floating and lock high
  a_r7_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> (tri_o && !up_o && !dn_o && lock_o));

  // R5: tri flag never coincides with a command
  a_r5_tri_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({up_o, dn_o, tri_o}) >= 1 && !(tri_o && (up_o || dn_o)));
endmodule

// File: tb/phase_det_bench.sv
`timescale 1ns/1ps
module phase_det_bench;
  localparam int WIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 1'b0, vco_p = 1'b0, pol = 1'b1, pwr_n = 1'b1;
  logic up, dn, tri_s, lock, mon;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  phase_det #(.LOCK_WIN(WIN)) u_phase_det (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(ref_p), .vco_pulse_i(vco_p),
    .pol_i(pol), .pwr_ni(pwr_n), .up_o(up), .dn_o(dn), .tri_o(tri_s),
    .lock_o(lock), .mon_o(mon)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a pulse pair, lead cycles apart; sample at negedges.
  task automatic run_pair(input int lead, input bit vco_first, input bit pd_mid,
                          output int n_up, output int n_dn, output int n_busy,
                          output int n_unlock, output int n_tri_err);
    int t = lead + 6;
    n_up = 0; n_dn = 0; n_busy = 0; n_unlock = 0; n_tri_err = 0;
    @(negedge clk);
    if (vco_first) vco_p = 1'b1; else ref_p = 1'b1;
    if (lead == 0) begin ref_p = 1'b1; vco_p = 1'b1; end
    for (int c = 0; c < t; c++) begin
      @(negedge clk);
      n_up += up; n_dn += dn; n_busy += !tri_s; n_unlock += !lock;
      if (tri_s != !(up || dn)) n_tri_err++;
      if (c == 1) begin
        if (vco_first) vco_p = 1'b0; else ref_p = 1'b0;
        if (pd_mid) pwr_n = 1'b0;
      end
      if (c == lead - 1) begin
        if (vco_first) ref_p = 1'b1; else vco_p = 1'b1;
      end
      if (c == lead + 1) begin ref_p = 1'b0; vco_p = 1'b0; end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 up", up, 0);
    check("R1 dn", dn, 0);
    check("R1 tri", tri_s, 1);
    check("R1 lock", lock, 1);
    check("R1 mon", mon, 0);
  endtask

  task automatic t_latency_mon;
    @(negedge clk); ref_p = 1'b1;
    @(negedge clk);
    check("R2 up one cycle after edge", up, 1);
    check("R10 mon follows ref", mon, 1);
    vco_p = 1'b1;
    @(negedge clk);
    check("R2 dn one cycle after edge", dn, 1);
    ref_p = 1'b0; vco_p = 1'b0;
    @(negedge clk);
    check("R3 both cleared", up | dn, 0);
    check("R10 mon low", mon, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ref_lead(input int lead);
    int u, d, b, l, te;
    pol = 1'b1;
    run_pair(lead, 1'b0, 1'b0, u, d, b, l, te);
    check($sformatf("R3 up len lead=%0d", lead), u, lead + 1);
    check($sformatf("R3 dn len lead=%0d", lead), d, 1);
    check($sformatf("R5 busy cycles lead=%0d", lead), b, lead + 1);
    check("R5 tri consistency", te, 0);
    check($sformatf("R9 unlock cycles lead=%0d", lead), l, (lead >= WIN) ? lead - WIN + 1 : 0);
  endtask

  task automatic t_vco_lead;
    int u, d, b, l, te;
    pol = 1'b1;
    run_pair(3, 1'b1, 1'b0, u, d, b, l, te);
    check("R3 vco lead dn len", d, 4);
    check("R3 vco lead up len", u, 1);
  endtask

  task automatic t_polarity;
    int u, d, b, l, te;
    pol = 1'b0;
    run_pair(5, 1'b0, 1'b0, u, d, b, l, te);
    check("R4 swapped dn len", d, 6);
    check("R4 swapped up len", u, 1);
    check("R9 unlock swapped", l, 2);
    pol = 1'b1;
  endtask

  task automatic t_coincident;
    int u, d, b, l, te;
    run_pair(0, 1'b0, 1'b0, u, d, b, l, te);
    check("R3 coincident up", u, 1);
    check("R3 coincident dn", d, 1);
  endtask

  task automatic t_powerdown;
    int u, d, b, l, te, seen;
    run_pair(6, 1'b0, 1'b1, u, d, b, l, te);
    check("R6 command not shortened", u, 7);
    check("R6 dn kept", d, 1);
    // now in power-down: pulses ignored
    seen = 0;
    @(negedge clk); ref_p = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      seen += up + dn + !tri_s + !lock;
      if (c == 2) vco_p = 1'b1;
    end
    check("R7 quiet in power-down", seen, 0);
    // release with inputs held high: no new edge
    pwr_n = 1'b1;
    seen = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      seen += up + dn;
    end
    check("R8 no stale edge on exit", seen, 0);
    ref_p = 1'b0; vco_p = 1'b0;
    repeat (2) @(negedge clk);
    run_pair(2, 1'b0, 1'b0, u, d, b, l, te);
    check("R8 normal after exit up", u, 3);
    check("R8 normal after exit dn", d, 1);
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency_mon();
    t_ref_lead(2);
    t_ref_lead(7);
    t_ref_lead(WIN);
    t_vco_lead();
    t_polarity();
    t_coincident();
    t_powerdown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule